// File: doc/BRIEF.md
# Pipelined Pixel Readout Timing Sequencer

This block produces the digital timing for a snapshot-mode infrared readout array of ROWS by COLS pixels. It walks the array one pixel per clock slot, across the columns of a row and then down the rows. For each slot it drives one-hot row and column selects and a per-pixel select, which is the AND of the two. While a pixel's select is high, the pixel's held value goes onto its column bus.

Each column amplifier is not sampled in the slot where it is selected. Its line-sync strobe fires SETTLE slots later, which gives the amplifier a long settling window. One slot after that strobe, the column bus is returned to the reference level by a reset pulse. The next pixel on the same bus then arrives a full line later. Because the window is long, the strobes of the last columns of a row land in the slots of the next row. The strobes of the final row land in the idle slots of the frame or in the first slots of the next frame.

A programmable frame period (in slots) sets the frame rate. Slots beyond the last pixel are idle. The enable input starts the scan and stops it only at a frame boundary. Each line-sync strobe comes with a valid flag and the row and column index of the pixel being sampled.

Top module: `roic_seq_top`

## Requirements
- R1: While active, in frame slot k < ROWS*COLS exactly one bit of row_sel is high, bit k/COLS, and exactly one bit of col_sel is high, bit k%COLS; each frame advances one pixel per clock.
- R2: pix_sel bit r*COLS+c equals row_sel[r] AND col_sel[c], so exactly one pix_sel bit is high in a scanning slot and none otherwise.
- R3: lsync[c] is high in exactly the cycle SETTLE clocks after col_sel[c] was high, and at no other time (SETTLE defaults to COLS-2).
- R4: col_rst[c] is high exactly one clock after lsync[c], and never in a cycle where col_sel[c] is high.
- R5: pixel_valid is high exactly when some lsync bit is high, and pix_row and pix_col then give the row and column of the pixel whose select was SETTLE clocks earlier.
- R6: The frame length in slots is P = max(frame_period, ROWS*COLS). frame_start is high for one cycle in slot 0 of each frame, and all selects are low in slots ROWS*COLS to P-1.
- R7: lsync, col_rst and pixel_valid for the last pixels of a frame still fire on schedule after that frame's select slots, whether the following slots are idle or belong to the next frame.
- R8: When idle with enable high, a frame starts at the next clock edge (frame_start is high in the cycle after that edge). enable is sampled only in the last slot of a frame: if it is low there, the scan stops after that frame. While enable stays low, no frame starts.
- R9: Synchronous reset drives every output low from the cycle after the reset edge and discards pending strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request, acted on at frame boundaries |
| frame_period | input | FPW | Frame length in slots; values below ROWS*COLS are raised to it |
| row_sel | output | ROWS | One-hot row select |
| col_sel | output | COLS | One-hot column select |
| pix_sel | output | ROWS*COLS | Per-pixel select, bit r*COLS+c |
| lsync | output | COLS | Per-column line-sync sample strobe |
| col_rst | output | COLS | Per-column bus reset pulse |
| frame_start | output | 1 | One-cycle pulse in slot 0 of each frame |
| pixel_valid | output | 1 | A settled pixel is being sampled this cycle |
| pix_row | output | clog2(ROWS) | Row index of the sampled pixel |
| pix_col | output | clog2(COLS) | Column index of the sampled pixel |

## Verification
If the slot counter or the row and column counters are corrupted, the error shows in the same cycle as a select in the wrong place or a select in an idle slot. If the settle delay line is corrupted, the error shows SETTLE cycles after the select as a strobe on the wrong column or in the wrong slot, and one cycle later the bus reset shows it again. The bench predicts every output in every cycle from the frame length and the elapsed slot count alone. A fault is therefore seen in the first cycle it reaches a port, including the strobes that spill over a frame boundary.

// File: rtl/roic_seq_pkg.sv
package roic_seq_pkg;

  // Index width for a count of items; never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Slots in one frame: the programmed period, but never shorter than the scan.
  function automatic logic [31:0] eff_period(input logic [31:0] fp, input logic [31:0] npix);
    return (fp < npix) ? npix : fp;
  endfunction

  // Flat position of pixel (r,c) in the per-pixel select vector.
  function automatic int unsigned pix_index(input int unsigned r, input int unsigned c,
                                            input int unsigned cols);
    return r * cols + c;
  endfunction

endpackage

// File: rtl/roic_scan_ctrl.sv
module roic_scan_ctrl
  import roic_seq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int FPW  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic [FPW-1:0]            frame_period,
  output logic                      scanning,
  output logic                      frame_start,
  output logic                      frame_last,
  output logic [idx_w(ROWS)-1:0]    row_idx,
  output logic [idx_w(COLS)-1:0]    col_idx
);
  localparam int NPIX = ROWS * COLS;
  localparam int RW   = idx_w(ROWS);
  localparam int CW   = idx_w(COLS);
  localparam int NPW  = $clog2(NPIX + 1);
  localparam int SW   = (FPW > NPW) ? FPW : NPW;

  logic          active_q;
  logic [SW-1:0] slot_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [31:0]   len_slots;
  logic          line_end;
  logic          scan_end;

  assign len_slots   = eff_period(32'(frame_period), 32'(NPIX));
  assign frame_last  = active_q && (32'(slot_q) >= (len_slots - 32'd1));
  assign scanning    = active_q && (32'(slot_q) < 32'(NPIX));
  assign frame_start = active_q && (slot_q == '0);
  assign line_end    = (col_q == CW'(COLS - 1));
  assign scan_end    = line_end && (row_q == RW'(ROWS - 1));
  assign row_idx     = row_q;
  assign col_idx     = col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
    end else if (!active_q) begin
      if (enable) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        row_q    <= '0;
        col_q    <= '0;
      end
    end else if (frame_last) begin
      // frame boundary: the only point where enable is honoured
      active_q <= enable;
      slot_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
    end else begin
      slot_q <= slot_q + SW'(1);
      if (scanning) begin
        if (line_end) begin
          col_q <= '0;
          row_q <= scan_end ? '0 : row_q + RW'(1);
        end else begin
          col_q <= col_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/roic_sel_decode.sv
module roic_sel_decode
  import roic_seq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                   scanning,
  input  logic [idx_w(ROWS)-1:0] row_idx,
  input  logic [idx_w(COLS)-1:0] col_idx,
  output logic [ROWS-1:0]        row_sel,
  output logic [COLS-1:0]        col_sel,
  output logic [ROWS*COLS-1:0]   pix_sel
);
  localparam int RW = idx_w(ROWS);
  localparam int CW = idx_w(COLS);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = scanning && (row_idx == RW'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel[c] = scanning && (col_idx == CW'(c));
  end

  // each pixel switch closes only where its row line and column line cross
  for (genvar r = 0; r < ROWS; r++) begin : g_pr
    for (genvar c = 0; c < COLS; c++) begin : g_pc
      assign pix_sel[pix_index(r, c, COLS)] = row_sel[r] & col_sel[c];
    end
  end

endmodule

// File: rtl/roic_settle_pipe.sv
module roic_settle_pipe
  import roic_seq_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int SETTLE = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scanning,
  input  logic [idx_w(ROWS)-1:0] row_idx,
  input  logic [idx_w(COLS)-1:0] col_idx,
  output logic                   sample_evt,
  output logic                   clear_evt,
  output logic [COLS-1:0]        lsync,
  output logic [COLS-1:0]        col_rst,
  output logic [idx_w(ROWS)-1:0] pix_row,
  output logic [idx_w(COLS)-1:0] pix_col
);
  localparam int RW     = idx_w(ROWS);
  localparam int CW     = idx_w(COLS);
  localparam int STAGES = SETTLE + 1;

  // stage k holds the select issued k+1 cycles ago
  logic          v_q [STAGES];
  logic [RW-1:0] r_q [STAGES];
  logic [CW-1:0] c_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) begin
        v_q[k] <= 1'b0;
        r_q[k] <= '0;
        c_q[k] <= '0;
      end
    end else begin
      v_q[0] <= scanning;
      r_q[0] <= row_idx;
      c_q[0] <= col_idx;
      for (int k = 1; k < STAGES; k++) begin
        v_q[k] <= v_q[k-1];
        r_q[k] <= r_q[k-1];
        c_q[k] <= c_q[k-1];
      end
    end
  end

  assign sample_evt = v_q[SETTLE-1];
  assign clear_evt  = v_q[SETTLE];
  assign pix_row    = sample_evt ? r_q[SETTLE-1] : '0;
  assign pix_col    = sample_evt ? c_q[SETTLE-1] : '0;

  for (genvar c = 0; c < COLS; c++) begin : g_strobe
    assign lsync[c]   = sample_evt && (c_q[SETTLE-1] == CW'(c));
    assign col_rst[c] = clear_evt  && (c_q[SETTLE]   == CW'(c));
  end

endmodule

// File: rtl/roic_seq_top.sv
module roic_seq_top
  import roic_seq_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int SETTLE = COLS - 2,
  parameter int FPW    = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   enable,
  input  logic [FPW-1:0]         frame_period,
  output logic [ROWS-1:0]        row_sel,
  output logic [COLS-1:0]        col_sel,
  output logic [ROWS*COLS-1:0]   pix_sel,
  output logic [COLS-1:0]        lsync,
  output logic [COLS-1:0]        col_rst,
  output logic                   frame_start,
  output logic                   pixel_valid,
  output logic [idx_w(ROWS)-1:0] pix_row,
  output logic [idx_w(COLS)-1:0] pix_col
);
  localparam int RW = idx_w(ROWS);
  localparam int CW = idx_w(COLS);

  // Elaboration guard: a bus reset must finish before the same bus is selected again.
  if (SETTLE < 1 || SETTLE + 1 >= COLS || FPW > 31 || ROWS < 1) begin : g_bad_cfg
    $error("roic_seq_top: need 1 <= SETTLE and SETTLE+1 < COLS, FPW <= 31");
  end

  logic          scanning;
  logic          frame_last;
  logic          sample_evt;
  logic          clear_evt;
  logic [RW-1:0] row_idx;
  logic [CW-1:0] col_idx;

  roic_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .FPW(FPW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .frame_period (frame_period),
    .scanning     (scanning),
    .frame_start  (frame_start),
    .frame_last   (frame_last),
    .row_idx      (row_idx),
    .col_idx      (col_idx)
  );

  roic_sel_decode #(.ROWS(ROWS), .COLS(COLS)) u_dec (
    .scanning (scanning),
    .row_idx  (row_idx),
    .col_idx  (col_idx),
    .row_sel  (row_sel),
    .col_sel  (col_sel),
    .pix_sel  (pix_sel)
  );

  roic_settle_pipe #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .scanning   (scanning),
    .row_idx    (row_idx),
    .col_idx    (col_idx),
    .sample_evt (sample_evt),
    .clear_evt  (clear_evt),
    .lsync      (lsync),
    .col_rst    (col_rst),
    .pix_row    (pix_row),
    .pix_col    (pix_col)
  );

  assign pixel_valid = sample_evt;

endmodule

// File: rtl/roic_seq_chk.sv
module roic_seq_chk
  import roic_seq_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   enable,
  input logic                   frame_last,
  input logic [ROWS-1:0]        row_sel,
  input logic [COLS-1:0]        col_sel,
  input logic [ROWS*COLS-1:0]   pix_sel,
  input logic [COLS-1:0]        lsync,
  input logic [COLS-1:0]        col_rst,
  input logic                   frame_start,
  input logic                   pixel_valid,
  input logic [idx_w(ROWS)-1:0] pix_row,
  input logic [idx_w(COLS)-1:0] pix_col
);

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel) && $onehot0(col_sel) && ((|row_sel) == (|col_sel)));

  assert_pix_cross_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pix_sel) && ((|pix_sel) == (|row_sel)));

  assert_lsync_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lsync));

  assert_reset_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (|lsync) |=> (col_rst == $past(lsync)));

  assert_reset_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    (col_rst & col_sel) == '0);

  assert_valid_col_R5: assert property (@(posedge clk) disable iff (rst)
    pixel_valid |-> (lsync[pix_col] && (32'(pix_row) < ROWS)));

  assert_valid_match_R5: assert property (@(posedge clk) disable iff (rst)
    pixel_valid == (|lsync));

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  assert_stop_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_last && !enable) |=> (!frame_start && (row_sel == '0)));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> ((row_sel == '0) && (col_sel == '0) && (lsync == '0) &&
             (col_rst == '0) && !frame_start && !pixel_valid));

endmodule

bind roic_seq_top roic_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .frame_last  (frame_last),
  .row_sel     (row_sel),
  .col_sel     (col_sel),
  .pix_sel     (pix_sel),
  .lsync       (lsync),
  .col_rst     (col_rst),
  .frame_start (frame_start),
  .pixel_valid (pixel_valid),
  .pix_row     (pix_row),
  .pix_col     (pix_col)
);

// File: tb/roic_seq_top_tb.sv
module roic_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 3;
  localparam int COLS   = 5;
  localparam int SETTLE = COLS - 2;
  localparam int FPW    = 16;
  localparam int NPIX   = ROWS * COLS;
  localparam int RW     = $clog2(ROWS);
  localparam int CW     = $clog2(COLS);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 enable = 1'b0;
  logic [FPW-1:0]       frame_period = '0;
  logic [ROWS-1:0]      row_sel;
  logic [COLS-1:0]      col_sel;
  logic [NPIX-1:0]      pix_sel;
  logic [COLS-1:0]      lsync;
  logic [COLS-1:0]      col_rst;
  logic                 frame_start;
  logic                 pixel_valid;
  logic [RW-1:0]        pix_row;
  logic [CW-1:0]        pix_col;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  roic_seq_top #(.ROWS(ROWS), .COLS(COLS), .SETTLE(SETTLE), .FPW(FPW)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .frame_period(frame_period),
    .row_sel(row_sel), .col_sel(col_sel), .pix_sel(pix_sel), .lsync(lsync),
    .col_rst(col_rst), .frame_start(frame_start), .pixel_valid(pixel_valid),
    .pix_row(pix_row), .pix_col(pix_col)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic all_quiet(input string req);
    chk(row_sel == '0 && col_sel == '0 && pix_sel == '0, req, "selects low", pix_sel, 0);
    chk(lsync == '0 && col_rst == '0, req, "strobes low", {lsync, col_rst}, 0);
    chk(!frame_start && !pixel_valid, req, "flags low", {frame_start, pixel_valid}, 0);
  endtask

  // Event at frame-relative cycle e is a scan slot when its frame was run and k < NPIX.
  function automatic bit is_slot(input int e, input int p, input int nf);
    return (e >= 0) && (e / p < nf) && (e % p < NPIX);
  endfunction

  // Run nf back-to-back frames of the given period and predict every cycle.
  task automatic run_frames(input int fp, input int nf, input string tag);
    int p;
    p = (fp < NPIX) ? NPIX : fp;
    frame_period = FPW'(fp);
    enable = 1'b1;
    @(negedge clk);
    for (int t = 0; t < nf * p + SETTLE + 3; t++) begin
      logic [ROWS-1:0] e_row;
      logic [COLS-1:0] e_col, e_ls, e_cr;
      logic [NPIX-1:0] e_pix;
      bit e_fs, e_v;
      int k, es, ec;
      string ls_req, cr_req;
      e_row = '0; e_col = '0; e_ls = '0; e_cr = '0; e_pix = '0; e_v = 1'b0;
      k = t % p;
      e_fs = (k == 0) && (t / p < nf);
      if (is_slot(t, p, nf)) begin
        e_row[k / COLS] = 1'b1;
        e_col[k % COLS] = 1'b1;
        e_pix[k] = 1'b1;
      end
      es = t - SETTLE;
      ec = t - SETTLE - 1;
      if (is_slot(es, p, nf)) begin
        e_ls[(es % p) % COLS] = 1'b1;
        e_v = 1'b1;
      end
      if (is_slot(ec, p, nf)) e_cr[(ec % p) % COLS] = 1'b1;
      // strobes that land outside the select slots of their own frame belong to R7
      ls_req = (es >= 0 && (es / p != t / p || k >= NPIX)) ? "R7" : "R3";
      cr_req = (ec >= 0 && (ec / p != t / p || k >= NPIX)) ? "R7" : "R4";
      chk(frame_start == e_fs, (t == 0) ? "R8" : "R6", {tag, " frame_start"}, frame_start, e_fs);
      chk(row_sel == e_row, k >= NPIX ? "R6" : "R1", {tag, " row_sel"}, row_sel, e_row);
      chk(col_sel == e_col, "R1", {tag, " col_sel"}, col_sel, e_col);
      chk(pix_sel == e_pix, "R2", {tag, " pix_sel"}, pix_sel, e_pix);
      chk(lsync == e_ls, ls_req, {tag, " lsync"}, lsync, e_ls);
      chk(col_rst == e_cr, cr_req, {tag, " col_rst"}, col_rst, e_cr);
      chk(pixel_valid == e_v, "R5", {tag, " pixel_valid"}, pixel_valid, e_v);
      if (e_v) begin
        chk(32'(pix_row) == (es % p) / COLS && 32'(pix_col) == (es % p) % COLS, "R5",
            {tag, " pixel index"}, {pix_row, pix_col}, es % p);
      end
      if (t == (nf - 1) * p) enable = 1'b0;  // drop inside the last frame (R8)
      @(negedge clk);
    end
  endtask

  task automatic test_reset_state();
    repeat (3) @(negedge clk);
    all_quiet("R9");
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_enable_low();
    enable = 1'b0;
    frame_period = FPW'(NPIX);
    for (int i = 0; i < 12; i++) begin
      all_quiet("R8");
      @(negedge clk);
    end
  endtask

  task automatic test_reset_mid_frame();
    frame_period = FPW'(NPIX);
    enable = 1'b1;
    @(negedge clk);
    chk(frame_start == 1'b1, "R8", "restart", frame_start, 1);
    repeat (SETTLE + 4) @(negedge clk);
    chk(pixel_valid == 1'b1, "R5", "strobe pending before reset", pixel_valid, 1);
    rst = 1'b1;
    enable = 1'b0;
    @(negedge clk);
    all_quiet("R9");
    rst = 1'b0;
    for (int i = 0; i < SETTLE + 3; i++) begin
      @(negedge clk);
      all_quiet("R9");
    end
  endtask

  initial begin
    @(negedge clk);
    test_reset_state();
    test_enable_low();
    run_frames(0, 2, "clamped");
    run_frames(NPIX + 6, 2, "idle");
    run_frames(NPIX + 1, 1, "single");
    run_frames(NPIX, 3, "exact");
    test_reset_mid_frame();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule